// File: doc/BRIEF.md
# Per-Function Reset Handshake Controller

This block sits beside a multi-function endpoint and carries out function-level resets one function at a time. A request arrives as a 0-to-1 transition on one bit of a physical-function request vector or of a separate virtual-function request vector. Each bit belongs to one function. The block then drives a local reset into that function's logic and keeps it asserted for a minimum hold time. After that it waits until the function reports that it is quiet. Only then does it raise the done bit that matches the request bit.

Every function has its own deadline counter. The count defaults to a tenth of a second at the configured clock frequency. If the function never reports quiet before the deadline, the block forces completion and sets a sticky timeout flag for that function. All functions run independently, so any mix of physical and virtual functions can be in reset at once.

Top module: `flr_handshake_ctrl`

## Requirements
- R1: A function's sequence starts only on a sampled 0-to-1 transition of its request bit. A request bit that is already high when reset releases, or that stays high after completion, starts nothing.
- R2: Bit i of the physical-function vectors and bit i of the virtual-function vectors each control a separate function. Requests on different functions, whether simultaneous or overlapping, do not affect one another.
- R3: The function reset output rises at the first clock edge that samples the request transition. It then stays high for MIN_RST_CYC cycles whatever the quiet input does. From the next cycle on, the first edge that samples quiet high ends the reset phase. If quiet is already high, the reset lasts exactly MIN_RST_CYC+1 cycles.
- R4: Done rises at the same edge where the function reset falls after a normal completion. Done holds while the request bit stays high and clears at the first edge that samples the request low.
- R5: If the reset phase reaches DEADLINE_CYC cycles without completing, the next edge drops the function reset, raises done and sets that function's timeout flag. The timeout flag then stays high until rst_n is asserted.
- R6: If the request bit drops during the reset phase, the next edge drops the function reset. Done is not raised and the function returns to idle.
- R7: While rst_n is low, every output is low at once, without waiting for a clock. Release is synchronised to clk.
- R8: If quiet is sampled high at the same edge where the deadline expires, the completion counts as normal and the timeout flag is not set.
- R9: Done and the function reset of the same function are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pf_flr_busy | input | NUM_PF | Per-physical-function reset request |
| vf_flr_busy | input | NUM_VF | Per-virtual-function reset request |
| pf_idle_ok | input | NUM_PF | Physical function reports it is quiet |
| vf_idle_ok | input | NUM_VF | Virtual function reports it is quiet |
| pf_fn_rst | output | NUM_PF | Local reset into each physical function |
| vf_fn_rst | output | NUM_VF | Local reset into each virtual function |
| pf_flr_ack | output | NUM_PF | Completion bit mirroring each physical request |
| vf_flr_ack | output | NUM_VF | Completion bit mirroring each virtual request |
| pf_late | output | NUM_PF | Sticky deadline-expired flag per physical function |
| vf_late | output | NUM_VF | Sticky deadline-expired flag per virtual function |

## Verification
Every result of this block follows a single registered stage. The function reset is visible in the cycle after the edge that sees the request rise. Done and the timeout flag appear in the cycle after the edge that sees quiet or the deadline. Done clears in the cycle after the edge that sees the request fall. A per-function bench model steps on the same edges as the design. All comparisons and directed checks are made on the falling edge, once the outputs registered at the rising edge have settled. Inputs change only on the falling edge. The directed checks place quiet exactly on the deadline cycle and raise a request before reset is released, so the boundary cycles are hit exactly.

// File: rtl/flr_pkg.sv
package flr_pkg;
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_HOLD  = 2'd1,
    FS_DRAIN = 2'd2,
    FS_ACK   = 2'd3
  } flr_state_e;
endpackage

// File: rtl/flr_rst_sync.sv
module flr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/flr_func_fsm.sv
module flr_func_fsm
  import flr_pkg::*;
#(
  parameter int unsigned MIN_RST_CYC  = 8,
  parameter int unsigned DEADLINE_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic quiet,
  output logic func_rst,
  output logic done,
  output logic timeout
);
  localparam int unsigned HW = $clog2(MIN_RST_CYC + 1);
  localparam int unsigned DW = $clog2(DEADLINE_CYC + 1);

  flr_state_e state_q, state_d;
  logic          req_q;
  logic [HW-1:0] hold_q, hold_d;
  logic [DW-1:0] dl_q, dl_d;
  logic          tmo_q, tmo_set;
  logic          req_rise, in_rst, dl_hit, hold_end, hold_en, dl_en;

  assign req_rise = req & ~req_q;
  assign in_rst   = (state_q == FS_HOLD) || (state_q == FS_DRAIN);
  assign dl_hit   = in_rst && (dl_q == DW'(DEADLINE_CYC - 1));
  assign hold_end = (hold_q == HW'(MIN_RST_CYC - 1));

  always_comb begin
    state_d = state_q;
    tmo_set = 1'b0;
    unique case (state_q)
      FS_IDLE:  if (req_rise) state_d = FS_HOLD;
      FS_HOLD: begin
        if (!req)          state_d = FS_IDLE;
        else if (dl_hit) begin
          state_d = FS_ACK;
          tmo_set = 1'b1;
        end
        else if (hold_end) state_d = FS_DRAIN;
      end
      FS_DRAIN: begin
        if (!req)        state_d = FS_IDLE;
        else if (quiet)  state_d = FS_ACK;
        else if (dl_hit) begin
          state_d = FS_ACK;
          tmo_set = 1'b1;
        end
      end
      FS_ACK:   if (!req) state_d = FS_IDLE;
      default:  state_d = FS_IDLE;
    endcase
  end

  assign hold_en = (state_q == FS_HOLD) || (hold_q != '0);
  assign hold_d  = (state_q == FS_HOLD) ? hold_q + 1'b1 : '0;
  assign dl_en   = in_rst || (dl_q != '0);
  assign dl_d    = in_rst ? dl_q + 1'b1 : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FS_IDLE;
      req_q   <= 1'b1;
      tmo_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req;
      if (tmo_set) tmo_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      dl_q   <= '0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      if (dl_en)   dl_q   <= dl_d;
    end
  end

  assign func_rst = in_rst;
  assign done     = (state_q == FS_ACK);
  assign timeout  = tmo_q;

  // Checker-only run-length counter of the local reset
  logic [DW:0] rlen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        rlen_q <= '0;
    else if (func_rst) rlen_q <= rlen_q + 1'b1;
    else               rlen_q <= '0;
  end

  p_min_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(func_rst) && done) |-> (rlen_q > (DW+1)'(MIN_RST_CYC)));
  p_quiet_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(func_rst) && done && !$rose(timeout)) |-> ($past(quiet) || $past(dl_hit)));
  p_ack_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !req) |=> !done);
  p_deadline_r5: assert property (@(posedge clk) disable iff (!rst_n)
    func_rst |-> (rlen_q < (DW+1)'(DEADLINE_CYC)));
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> timeout);
  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (func_rst && !req) |=> (!func_rst && !done));
  p_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(func_rst && done));

  initial begin
    a_cfg_r5: assert (DEADLINE_CYC > MIN_RST_CYC + 1 && MIN_RST_CYC >= 1);
  end
endmodule

// File: rtl/flr_bank.sv
module flr_bank #(
  parameter int unsigned N_FUNC       = 2,
  parameter int unsigned MIN_RST_CYC  = 8,
  parameter int unsigned DEADLINE_CYC = 10_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_FUNC-1:0] req,
  input  logic [N_FUNC-1:0] quiet,
  output logic [N_FUNC-1:0] func_rst,
  output logic [N_FUNC-1:0] done,
  output logic [N_FUNC-1:0] timeout
);
  for (genvar g = 0; g < N_FUNC; g++) begin : g_fn
    flr_func_fsm #(
      .MIN_RST_CYC (MIN_RST_CYC),
      .DEADLINE_CYC(DEADLINE_CYC)
    ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req[g]),
      .quiet   (quiet[g]),
      .func_rst(func_rst[g]),
      .done    (done[g]),
      .timeout (timeout[g])
    );
  end
endmodule

// File: rtl/flr_handshake_ctrl.sv
module flr_handshake_ctrl #(
  parameter int unsigned NUM_PF       = 2,
  parameter int unsigned NUM_VF       = 4,
  parameter int unsigned MIN_RST_CYC  = 8,
  parameter int unsigned CLK_FREQ_HZ  = 100_000_000,
  parameter int unsigned DEADLINE_CYC = CLK_FREQ_HZ / 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_PF-1:0] pf_flr_busy,
  input  logic [NUM_VF-1:0] vf_flr_busy,
  input  logic [NUM_PF-1:0] pf_idle_ok,
  input  logic [NUM_VF-1:0] vf_idle_ok,
  output logic [NUM_PF-1:0] pf_fn_rst,
  output logic [NUM_VF-1:0] vf_fn_rst,
  output logic [NUM_PF-1:0] pf_flr_ack,
  output logic [NUM_VF-1:0] vf_flr_ack,
  output logic [NUM_PF-1:0] pf_late,
  output logic [NUM_VF-1:0] vf_late
);
  logic rst_core_n;

  flr_rst_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_core_n)
  );

  flr_bank #(
    .N_FUNC      (NUM_PF),
    .MIN_RST_CYC (MIN_RST_CYC),
    .DEADLINE_CYC(DEADLINE_CYC)
  ) u_pf (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .req     (pf_flr_busy),
    .quiet   (pf_idle_ok),
    .func_rst(pf_fn_rst),
    .done    (pf_flr_ack),
    .timeout (pf_late)
  );

  flr_bank #(
    .N_FUNC      (NUM_VF),
    .MIN_RST_CYC (MIN_RST_CYC),
    .DEADLINE_CYC(DEADLINE_CYC)
  ) u_vf (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .req     (vf_flr_busy),
    .quiet   (vf_idle_ok),
    .func_rst(vf_fn_rst),
    .done    (vf_flr_ack),
    .timeout (vf_late)
  );

  p_reset_quiet_r7: assert property (@(posedge clk)
    !rst_n |-> (pf_fn_rst == '0 && vf_fn_rst == '0 && pf_flr_ack == '0 &&
                vf_flr_ack == '0 && pf_late == '0 && vf_late == '0));
endmodule

// File: tb/flr_handshake_ctrl_tb_top.sv
module flr_handshake_ctrl_tb_top;
  localparam int NPF = 2;
  localparam int NVF = 4;
  localparam int NF  = NPF + NVF;
  localparam int MINC = 8;
  localparam int DLC  = 40;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [NPF-1:0] pf_busy, pf_ok, pf_rst, pf_ack, pf_late;
  logic [NVF-1:0] vf_busy, vf_ok, vf_rst, vf_ack, vf_late;

  flr_handshake_ctrl #(
    .NUM_PF(NPF), .NUM_VF(NVF), .MIN_RST_CYC(MINC), .DEADLINE_CYC(DLC)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .pf_flr_busy(pf_busy), .vf_flr_busy(vf_busy),
    .pf_idle_ok(pf_ok), .vf_idle_ok(vf_ok),
    .pf_fn_rst(pf_rst), .vf_fn_rst(vf_rst),
    .pf_flr_ack(pf_ack), .vf_flr_ack(vf_ack),
    .pf_late(pf_late), .vf_late(vf_late)
  );

  int n_run = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  // Reference model built from the requirements: 0 idle, 1 resetting, 2 done
  int ph [NF];
  int cyc[NF];
  bit prv[NF];
  bit mlt[NF];

  function automatic logic [NF-1:0] req_v();
    return {vf_busy, pf_busy};
  endfunction
  function automatic logic [NF-1:0] ok_v();
    return {vf_ok, pf_ok};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NF; i++) begin
        ph[i] = 0; cyc[i] = 0; prv[i] = 1'b1; mlt[i] = 1'b0;
      end
    end else begin
      logic [NF-1:0] r, q;
      r = req_v();
      q = ok_v();
      for (int i = 0; i < NF; i++) begin
        case (ph[i])
          0: if (r[i] && !prv[i]) begin ph[i] = 1; cyc[i] = 1; end
          1: begin
            if (!r[i]) ph[i] = 0;
            else if (cyc[i] >= MINC + 1 && q[i]) ph[i] = 2;
            else if (cyc[i] == DLC) begin ph[i] = 2; mlt[i] = 1'b1; end
            else cyc[i] = cyc[i] + 1;
          end
          default: if (!r[i]) ph[i] = 0;
        endcase
        prv[i] = r[i];
      end
    end
  end

  function automatic logic [NF-1:0] exp_vec(input int kind);
    logic [NF-1:0] v;
    for (int i = 0; i < NF; i++)
      v[i] = (kind == 0) ? (ph[i] == 1) : (kind == 1) ? (ph[i] == 2) : mlt[i];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [NF-1:0] act, input logic [NF-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R3 fn_rst", {vf_rst, pf_rst}, exp_vec(0));
    chk("R4 ack",    {vf_ack, pf_ack}, exp_vec(1));
    chk("R5 late",   {vf_late, pf_late}, exp_vec(2));
  endtask

  task automatic tick();
    @(negedge clk);
    compare_all();
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    #(150000 * 10);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
      $finish;
    end
  end

  initial begin
    process::self().srandom(32'd20240611);
    rst_n = 1'b0; pf_busy = '0; vf_busy = '0; pf_ok = '0; vf_ok = '0;
    repeat (3) @(negedge clk);
    chk("R7 reset outputs", {pf_rst, vf_rst, pf_ack, vf_ack, pf_late, vf_late}, '0);

    // R1: request already high across reset release starts nothing
    pf_busy[0] = 1'b1;
    rst_n = 1'b1;
    repeat (5) tick();
    chk1("R1 held level no start", pf_rst[0], 1'b0);
    pf_busy[0] = 1'b0;
    tick();

    // R3: quiet high from the start -> reset exactly MINC+1 cycles
    pf_ok[0] = 1'b1;
    pf_busy[0] = 1'b1;
    repeat (MINC + 1) tick();
    chk1("R3 reset still high at MIN+1", pf_rst[0], 1'b1);
    tick();
    chk1("R3 reset ended", pf_rst[0], 1'b0);
    chk1("R4 ack raised", pf_ack[0], 1'b1);
    repeat (3) tick();
    chk1("R4 ack held", pf_ack[0], 1'b1);
    chk1("R1 no restart while held", pf_rst[0], 1'b0);
    pf_busy[0] = 1'b0;
    tick();
    chk1("R4 ack cleared", pf_ack[0], 1'b0);

    // R6: abort by dropping the request mid-reset
    pf_busy[1] = 1'b1;
    repeat (3) tick();
    pf_busy[1] = 1'b0;
    tick();
    chk1("R6 abort drops reset", pf_rst[1], 1'b0);
    chk1("R6 abort no ack", pf_ack[1], 1'b0);

    // R5: quiet never comes on vf1; R8: quiet exactly at deadline on vf0
    vf_busy[1] = 1'b1;
    vf_busy[0] = 1'b1;
    repeat (DLC) tick();
    chk1("R5 reset high through deadline", vf_rst[1], 1'b1);
    vf_ok[0] = 1'b1;
    tick();
    chk1("R5 ack forced", vf_ack[1], 1'b1);
    chk1("R5 late set", vf_late[1], 1'b1);
    chk1("R8 ack on deadline quiet", vf_ack[0], 1'b1);
    chk1("R8 no late", vf_late[0], 1'b0);
    chk1("R2 other pf untouched", pf_late[0], 1'b0);
    vf_busy[1] = 1'b0; vf_busy[0] = 1'b0; vf_ok[0] = 1'b0;
    repeat (4) tick();
    chk1("R5 late sticky", vf_late[1], 1'b1);

    // Constrained random: overlapping requests on all functions (R2)
    for (int c = 0; c < 3000; c++) begin
      logic [NF-1:0] r, q;
      r = req_v();
      for (int i = 0; i < NF; i++) begin
        int lim;
        lim = (i % 2 == 1 && i >= NPF) ? 45 : 5;
        q[i] = ($urandom % lim) == 0;
        case (ph[i])
          0: if (r[i]) r[i] = 1'b0; else r[i] = ($urandom % 8) == 0;
          1: if (($urandom % 60) == 0) r[i] = 1'b0;
          default: if (($urandom % 3) == 0) r[i] = 1'b0;
        endcase
      end
      {vf_busy, pf_busy} = r;
      {vf_ok, pf_ok} = q;
      tick();
    end

    // R7: asynchronous reset mid-operation
    pf_busy = '1; vf_busy = '1; pf_ok = '0; vf_ok = '0;
    repeat (3) tick();
    #2 rst_n = 1'b0;
    #1 chk("R7 async clear", {pf_rst, vf_rst, pf_ack, vf_ack, pf_late, vf_late}, '0);
    pf_busy = '0; vf_busy = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick();

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule